// File: doc/BRIEF.md
# SPI Transmit Descriptor Ring Controller

This block feeds an SPI byte shifter from a ring of transmit descriptors held in a small local table. Each descriptor has three 16-bit words: a control/status word, a byte count and a buffer start address. The host fills a descriptor, sets its ready bit and hands it over. The engine then reads the buffer bytes from an external byte-addressed memory that has one cycle of read latency, and passes them one at a time to the shifter over a valid/ready handshake. When the buffer is finished, or is cut short by an error, the engine writes completion status back into the descriptor.

The host reaches everything through one 8-bit address space with writes and combinational reads. When address bit 7 is 0 the host sees the registers:

| Address | Register |
|---------|----------|
| 0x00 | mode (bit 0: 1 = master) |
| 0x01 | ring base index |
| 0x02 | event flags (bit 0 buffer done, bit 1 buffer error, write 1 to clear) |
| 0x03 | event mask |
| 0x04 | command (bit 0 restart at base, bit 1 poll, write-only, reads 0) |

When address bit 7 is 1 the host sees descriptor words: bits [4:2] select the descriptor and bits [1:0] select the word (0 control, 1 count, 2 start address).

The control word bits are: ready 15, wrap 13, interrupt 12, last 11, continuous 9, underrun 1 and multi-master error 0. The remaining bits are spare. Slave-select from another master arrives on `ss_in`, active high.

Top module: `spi_txring`

## Requirements
- R1: After reset `tx_valid`, `tx_last` and `irq` are 0, all registers read 0, and the engine waits without sending.
- R2: A restart command while the engine waits moves it to the descriptor at the base index. For each descriptor with ready (bit 15) set, it sends `count` bytes in order, starting at the start address, then clears ready.
- R3: After a descriptor with wrap (bit 13) set, the engine goes back to the base index. Descriptors are otherwise serviced in rising index order.
- R4: On a descriptor whose ready bit is 0 the engine waits there and sends nothing, even if later descriptors are ready. A poll command re-examines the same descriptor.
- R5: With interrupt (bit 12) set, closing a buffer sets event bit 0 on success or event bit 1 on error. With bit 12 clear, no event is set. `irq` is high while any event bit and its mask bit are both 1.
- R6: `tx_last` is high together with the final byte of a buffer whose last bit (bit 11) is set, and at no other time.
- R7: In master mode a descriptor with continuous (bit 9) set keeps ready at close, so it is sent again on the next pass. In slave mode bit 9 is ignored and ready is cleared.
- R8: In slave mode, if `tx_ready` is high while no byte is offered inside a buffer, the buffer closes with underrun (bit 1) set and ready cleared.
- R9: In master mode, `ss_in` high while a buffer is being sent closes it at once: no further byte is offered, multi-master error (bit 0) is set and ready is cleared.
- R10: Status bits 1:0 are cleared when a descriptor is opened and are written only at close. The spare bits 14, 10 and 8..2 come back unchanged.
- R11: Event bits are sticky. Writing 1 to an event bit clears it, and writing 0 leaves it unchanged.
- R12: A ready descriptor with count 0 closes at once as a success, with no byte sent.
- R13: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 8 | Host address (bit 7 selects the descriptor table) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, combinational on `host_addr` |
| buf_addr | output | 16 | Buffer memory byte address |
| buf_rdata | input | 8 | Buffer memory data, one cycle after `buf_addr` |
| tx_valid | output | 1 | A byte is offered to the shifter |
| tx_data | output | 8 | Offered byte |
| tx_last | output | 1 | Offered byte ends a message |
| tx_ready | input | 1 | Shifter takes or requests a byte |
| ss_in | input | 1 | Slave-select driven by another master |
| irq | output | 1 | Masked event interrupt |

## Verification
A wrong engine pointer shows up as bytes arriving out of ring order, or as a not-ready descriptor being skipped. The byte stream seen by the shifter exposes either one within a few cycles of the descriptor being opened. A wrong close word, such as a lost spare bit, a stale status bit or ready left set, can be read back by the host on the cycle after close. Errors raised in the wrong mode show up as missing or extra bytes and as the wrong event bit. A hold violation on the handshake shows as changed data during a stall.

// File: rtl/txr_pkg.sv
package txr_pkg;

    localparam int unsigned B_READY = 15;
    localparam int unsigned B_WRAP  = 13;
    localparam int unsigned B_INTR  = 12;
    localparam int unsigned B_LAST  = 11;
    localparam int unsigned B_CONT  = 9;
    localparam int unsigned B_UNDR  = 1;
    localparam int unsigned B_MMERR = 0;

    localparam logic [15:0] STATUS_BITS = 16'h0003;

    localparam logic [6:0] REG_MODE  = 7'd0;
    localparam logic [6:0] REG_BASE  = 7'd1;
    localparam logic [6:0] REG_EVENT = 7'd2;
    localparam logic [6:0] REG_MASK  = 7'd3;
    localparam logic [6:0] REG_CMD   = 7'd4;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_OPEN,
        ST_LOAD,
        ST_SEND,
        ST_CLOSE
    } eng_state_e;

    typedef struct packed {
        logic wrap;
        logic intr;
        logic last;
        logic cont;
    } desc_flags_t;

    function automatic desc_flags_t decode_flags(input logic [15:0] w);
        desc_flags_t f;
        f.wrap = w[B_WRAP];
        f.intr = w[B_INTR];
        f.last = w[B_LAST];
        f.cont = w[B_CONT];
        return f;
    endfunction

    function automatic logic [15:0] close_word(input logic [15:0] w, input logic keep,
                                               input logic un, input logic me);
        logic [15:0] r;
        r          = w;
        r[B_READY] = keep;
        r[B_UNDR]  = un;
        r[B_MMERR] = me;
        return r;
    endfunction

endpackage

// File: rtl/txr_regs.sv
module txr_regs
    import txr_pkg::*;
#(
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [6:0]    addr,
    input  logic [15:0]   wdata,
    input  logic [1:0]    ev_set,
    output logic          master,
    output logic [IW-1:0] base,
    output logic [1:0]    events,
    output logic [1:0]    mask,
    output logic          cmd_restart,
    output logic          cmd_poll,
    output logic          irq,
    output logic [15:0]   rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            master <= 1'b0;
            base   <= '0;
            events <= '0;
            mask   <= '0;
        end else begin
            if (wr && addr == REG_MODE) master <= wdata[0];
            if (wr && addr == REG_BASE) base <= wdata[IW-1:0];
            if (wr && addr == REG_MASK) mask <= wdata[1:0];
            if (wr && addr == REG_EVENT)
                events <= (events & ~wdata[1:0]) | ev_set;
            else
                events <= events | ev_set;
        end
    end

    assign cmd_restart = wr && addr == REG_CMD && wdata[0];
    assign cmd_poll    = wr && addr == REG_CMD && wdata[1];
    assign irq         = |(events & mask);

    always_comb begin
        rdata = '0;
        case (addr)
            REG_MODE:  rdata[0] = master;
            REG_BASE:  rdata[IW-1:0] = base;
            REG_EVENT: rdata[1:0] = events;
            REG_MASK:  rdata[1:0] = mask;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/txr_desc_mem.sv
module txr_desc_mem #(
    parameter int NDESC = 8,
    parameter int IW    = 3,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          h_we,
    input  logic [IW-1:0] h_idx,
    input  logic [1:0]    h_word,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    input  logic [IW-1:0] e_idx,
    input  logic          e_we,
    input  logic [DW-1:0] e_ctrl,
    output logic [DW-1:0] e_ctrl_rd,
    output logic [DW-1:0] e_cnt_rd,
    output logic [DW-1:0] e_adr_rd
);

    logic [NDESC-1:0][DW-1:0] ctrl_a;
    logic [NDESC-1:0][DW-1:0] cnt_a;
    logic [NDESC-1:0][DW-1:0] adr_a;

    for (genvar g = 0; g < NDESC; g++) begin : g_slot
        logic [DW-1:0] c_q, n_q, a_q;
        logic          hit_h, hit_e;
        assign hit_h = h_we && h_idx == IW'(g);
        assign hit_e = e_we && e_idx == IW'(g);

        always_ff @(posedge clk) begin
            if (rst) begin
                c_q <= '0;
                n_q <= '0;
                a_q <= '0;
            end else begin
                if (hit_e)
                    c_q <= e_ctrl;
                else if (hit_h && h_word == 2'd0)
                    c_q <= h_wdata;
                if (hit_h && h_word == 2'd1) n_q <= h_wdata;
                if (hit_h && h_word == 2'd2) a_q <= h_wdata;
            end
        end

        assign ctrl_a[g] = c_q;
        assign cnt_a[g]  = n_q;
        assign adr_a[g]  = a_q;
    end

    always_comb begin
        case (h_word)
            2'd0:    h_rdata = ctrl_a[h_idx];
            2'd1:    h_rdata = cnt_a[h_idx];
            2'd2:    h_rdata = adr_a[h_idx];
            default: h_rdata = '0;
        endcase
    end

    assign e_ctrl_rd = ctrl_a[e_idx];
    assign e_cnt_rd  = cnt_a[e_idx];
    assign e_adr_rd  = adr_a[e_idx];

endmodule

// File: rtl/txr_engine.sv
module txr_engine
    import txr_pkg::*;
#(
    parameter int NDESC = 8,
    parameter int IW    = 3,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          master,
    input  logic [IW-1:0] base,
    input  logic          cmd_restart,
    input  logic          cmd_poll,
    input  logic [DW-1:0] d_ctrl,
    input  logic [DW-1:0] d_cnt,
    input  logic [DW-1:0] d_adr,
    output logic [IW-1:0] d_idx,
    output logic          d_we,
    output logic [DW-1:0] d_wctrl,
    output logic [1:0]    ev_set,
    output logic [DW-1:0] buf_addr,
    input  logic [7:0]    buf_rdata,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    input  logic          tx_ready,
    input  logic          ss_in,
    output eng_state_e    state
);

    localparam logic [IW-1:0] LAST_SLOT = IW'(NDESC - 1);

    eng_state_e    state_q;
    logic [IW-1:0] ptr_q;
    logic [DW-1:0] idx_q, cnt_q, start_q;
    desc_flags_t   flags_q;
    logic          un_q, me_q;

    logic final_byte, clash, starve, keep_ready, failed;
    logic [IW-1:0] next_ptr;

    assign final_byte = idx_q == cnt_q - 1'b1;
    assign clash      = master && ss_in;
    assign starve     = !master && tx_ready;
    assign failed     = un_q || me_q;
    assign keep_ready = flags_q.cont && master && !failed;
    assign next_ptr   = (flags_q.wrap || ptr_q == LAST_SLOT) ? base : ptr_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT;
            ptr_q   <= '0;
            idx_q   <= '0;
            cnt_q   <= '0;
            start_q <= '0;
            flags_q <= '0;
            un_q    <= 1'b0;
            me_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_WAIT: begin
                    if (cmd_restart) begin
                        ptr_q   <= base;
                        state_q <= ST_OPEN;
                    end else if (cmd_poll) begin
                        state_q <= ST_OPEN;
                    end
                end
                ST_OPEN: begin
                    if (d_ctrl[B_READY]) begin
                        flags_q <= decode_flags(d_ctrl);
                        cnt_q   <= d_cnt;
                        start_q <= d_adr;
                        idx_q   <= '0;
                        un_q    <= 1'b0;
                        me_q    <= 1'b0;
                        state_q <= (d_cnt == '0) ? ST_CLOSE : ST_LOAD;
                    end else begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_LOAD: begin
                    if (clash) begin
                        me_q    <= 1'b1;
                        state_q <= ST_CLOSE;
                    end else if (starve) begin
                        un_q    <= 1'b1;
                        state_q <= ST_CLOSE;
                    end else begin
                        state_q <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (clash) begin
                        me_q    <= 1'b1;
                        state_q <= ST_CLOSE;
                    end else if (tx_ready) begin
                        if (final_byte) begin
                            state_q <= ST_CLOSE;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= ST_LOAD;
                        end
                    end
                end
                ST_CLOSE: begin
                    ptr_q   <= next_ptr;
                    state_q <= ST_OPEN;
                end
                default: state_q <= ST_WAIT;
            endcase
        end
    end

    always_comb begin
        d_we    = 1'b0;
        d_wctrl = d_ctrl;
        ev_set  = 2'b00;
        if (state_q == ST_OPEN && d_ctrl[B_READY]) begin
            d_we    = 1'b1;
            d_wctrl = d_ctrl & ~STATUS_BITS;
        end else if (state_q == ST_CLOSE) begin
            d_we    = 1'b1;
            d_wctrl = close_word(d_ctrl, keep_ready, un_q, me_q);
            if (flags_q.intr) ev_set = failed ? 2'b10 : 2'b01;
        end
    end

    assign d_idx    = ptr_q;
    assign buf_addr = start_q + idx_q;
    assign tx_valid = state_q == ST_SEND;
    assign tx_data  = buf_rdata;
    assign tx_last  = state_q == ST_SEND && flags_q.last && final_byte;
    assign state    = state_q;

endmodule

// File: rtl/spi_txring.sv
module spi_txring
    import txr_pkg::*;
#(
    parameter int NDESC = 8,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_wr,
    input  logic [7:0]    host_addr,
    input  logic [15:0]   host_wdata,
    output logic [15:0]   host_rdata,
    output logic [DW-1:0] buf_addr,
    input  logic [7:0]    buf_rdata,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    input  logic          tx_ready,
    input  logic          ss_in,
    output logic          irq
);

    localparam int IW = (NDESC > 1) ? $clog2(NDESC) : 1;

    logic          master_w, cmd_restart_w, cmd_poll_w;
    logic [IW-1:0] base_w, d_idx_w;
    logic [1:0]    events_w, mask_w, ev_set_w;
    logic [15:0]   reg_rdata_w, desc_rdata_w;
    logic [DW-1:0] d_ctrl_w, d_cnt_w, d_adr_w, d_wctrl_w;
    logic          d_we_w, sel_desc;
    eng_state_e    eng_state_w;

    assign sel_desc = host_addr[7];

    txr_regs #(.IW(IW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (host_wr && !sel_desc),
        .addr       (host_addr[6:0]),
        .wdata      (host_wdata),
        .ev_set     (ev_set_w),
        .master     (master_w),
        .base       (base_w),
        .events     (events_w),
        .mask       (mask_w),
        .cmd_restart(cmd_restart_w),
        .cmd_poll   (cmd_poll_w),
        .irq        (irq),
        .rdata      (reg_rdata_w)
    );

    txr_desc_mem #(.NDESC(NDESC), .IW(IW), .DW(DW)) u_desc (
        .clk      (clk),
        .rst      (rst),
        .h_we     (host_wr && sel_desc),
        .h_idx    (host_addr[IW+1:2]),
        .h_word   (host_addr[1:0]),
        .h_wdata  (DW'(host_wdata)),
        .h_rdata  (desc_rdata_w),
        .e_idx    (d_idx_w),
        .e_we     (d_we_w),
        .e_ctrl   (d_wctrl_w),
        .e_ctrl_rd(d_ctrl_w),
        .e_cnt_rd (d_cnt_w),
        .e_adr_rd (d_adr_w)
    );

    txr_engine #(.NDESC(NDESC), .IW(IW), .DW(DW)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .master     (master_w),
        .base       (base_w),
        .cmd_restart(cmd_restart_w),
        .cmd_poll   (cmd_poll_w),
        .d_ctrl     (d_ctrl_w),
        .d_cnt      (d_cnt_w),
        .d_adr      (d_adr_w),
        .d_idx      (d_idx_w),
        .d_we       (d_we_w),
        .d_wctrl    (d_wctrl_w),
        .ev_set     (ev_set_w),
        .buf_addr   (buf_addr),
        .buf_rdata  (buf_rdata),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_last    (tx_last),
        .tx_ready   (tx_ready),
        .ss_in      (ss_in),
        .state      (eng_state_w)
    );

    assign host_rdata = sel_desc ? desc_rdata_w : reg_rdata_w;

endmodule

// File: rtl/txr_checker.sv
module txr_checker
    import txr_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_data,
    input logic        tx_last,
    input logic        ss_in,
    input logic        master,
    input logic [1:0]  events,
    input logic        host_wr,
    input logic [7:0]  host_addr,
    input logic [15:0] host_wdata,
    input eng_state_e  state
);

    logic ev0_clear;
    assign ev0_clear = host_wr && host_addr == 8'h02 && host_wdata[0];

    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid); // R6

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready && !(master && ss_in) |=> tx_valid && $stable(tx_data)); // R13

    AST_CLASH_DROPS_VALID: assert property (@(posedge clk) disable iff (rst)
        master && ss_in && tx_valid |=> !tx_valid); // R9

    AST_STARVE_CLOSES: assert property (@(posedge clk) disable iff (rst)
        !master && state == ST_LOAD && tx_ready |=> state == ST_CLOSE); // R8

    AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (rst)
        events[0] && !ev0_clear |=> events[0]); // R11

    AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (rst)
        state == ST_WAIT |-> !tx_valid); // R4

endmodule

bind spi_txring txr_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .ss_in     (ss_in),
    .master    (master_w),
    .events    (events_w),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .state     (eng_state_w)
);

// File: tb/sim_spi_txring.sv
`timescale 1ns/1ps
module sim_spi_txring;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [15:0] buf_addr;
    logic [7:0]  buf_rdata;
    logic        tx_valid, tx_last, tx_ready, irq;
    logic [7:0]  tx_data;
    logic        ss_in = 1'b0;
    logic [1:0]  rdy_mode = 2'd1;

    int checks = 0;
    int errors = 0;
    int rx_total = 0;
    logic [7:0] rx_d [256];
    logic       rx_l [256];
    logic [7:0] bmem [256];

    always #2 clk = ~clk;

    assign tx_ready = (rdy_mode == 2'd1) || (rdy_mode == 2'd2 && tx_valid);

    spi_txring u0 (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .buf_addr(buf_addr),
        .buf_rdata(buf_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_ready(tx_ready), .ss_in(ss_in), .irq(irq)
    );

    function automatic logic [7:0] bval(input logic [7:0] a);
        return 8'(a * 8'd7 + 8'd3);
    endfunction

    initial for (int i = 0; i < 256; i++) bmem[i] = bval(8'(i));

    always_ff @(posedge clk) buf_rdata <= bmem[buf_addr[7:0]];

    always @(negedge clk) begin
        if (!rst && tx_valid && tx_ready) begin
            rx_d[rx_total[7:0]] = tx_data;
            rx_l[rx_total[7:0]] = tx_last;
            rx_total = rx_total + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hr(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    function automatic logic [7:0] da(input int i, input int w);
        return 8'h80 | 8'(i << 2) | 8'(w);
    endfunction

    task automatic prog(input int i, input logic [15:0] ctrl, input logic [15:0] cnt,
                        input logic [15:0] adr);
        hw(da(i, 1), cnt);
        hw(da(i, 2), adr);
        hw(da(i, 0), ctrl);
    endtask

    task automatic wait_clear(input int i, input string req);
        logic [15:0] v;
        int n;
        n = 0;
        v = 16'h8000;
        while (v[15] && n < 3000) begin
            hr(da(i, 0), v);
            n++;
        end
        check(req, {31'd0, v[15]}, 32'd0);
    endtask

    localparam logic [47:0] VEC [4] = '{
        48'hB803_0003_0010,
        48'hA000_0001_0020,
        48'hF9FC_0002_0030,
        48'hB000_0000_0040
    };

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v, ctl, cnt, adr;
        int base_n;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 tx_valid", {31'd0, tx_valid}, 0);
        check("R1 irq", {31'd0, irq}, 0);
        hr(8'h02, v); check("R1 events", v, 0);
        hr(8'h00, v); check("R1 mode", v, 0);
        repeat (10) @(negedge clk);
        check("R1 no bytes", rx_total, 0);

        hw(8'h00, 16'h0001);

        // vector table: R2 R5 R6 R10 R12
        foreach (VEC[k]) begin
            ctl = VEC[k][47:32]; cnt = VEC[k][31:16]; adr = VEC[k][15:0];
            hw(8'h02, 16'h0003);
            base_n = rx_total;
            prog(0, ctl, cnt, adr);
            hw(8'h04, 16'h0001);
            wait_clear(0, "R2 ready cleared");
            repeat (4) @(negedge clk);
            check("R2/R12 byte count", rx_total - base_n, 32'(cnt));
            for (int b = 0; b < int'(cnt); b++) begin
                check("R2 byte", rx_d[8'(base_n + b)], bval(8'(adr + 16'(b))));
                check("R6 last flag", {31'd0, rx_l[8'(base_n + b)]},
                      {31'd0, ctl[11] && b == int'(cnt) - 1});
            end
            hr(da(0, 0), v);
            check("R10 close word", v, ctl & 16'h7FFC);
            hr(8'h02, v);
            check("R5 event", v, {15'd0, ctl[12]});
        end

        // R3 ring order and wrap
        base_n = rx_total;
        prog(0, 16'h8000, 1, 16'h40);
        prog(1, 16'h8000, 2, 16'h50);
        prog(2, 16'hA000, 1, 16'h60);
        hw(8'h04, 16'h0001);
        wait_clear(2, "R3 last slot");
        repeat (6) @(negedge clk);
        check("R3 count", rx_total - base_n, 4);
        check("R3 b0", rx_d[8'(base_n)], bval(8'h40));
        check("R3 b1", rx_d[8'(base_n + 1)], bval(8'h50));
        check("R3 b2", rx_d[8'(base_n + 2)], bval(8'h51));
        check("R3 b3", rx_d[8'(base_n + 3)], bval(8'h60));

        // R4 no skip past a not-ready descriptor
        base_n = rx_total;
        prog(1, 16'h8000, 1, 16'h70);
        hw(8'h04, 16'h0002);
        repeat (30) @(negedge clk);
        check("R4 nothing sent", rx_total - base_n, 0);
        hr(da(1, 0), v);
        check("R4 later slot untouched", {31'd0, v[15]}, 1);
        prog(0, 16'h8000, 1, 16'h80);
        hw(8'h04, 16'h0002);
        wait_clear(1, "R4 resumed");
        repeat (4) @(negedge clk);
        check("R4 count", rx_total - base_n, 2);
        check("R4 first", rx_d[8'(base_n)], bval(8'h80));
        check("R4 second", rx_d[8'(base_n + 1)], bval(8'h70));

        // R7 continuous mode in master
        base_n = rx_total;
        prog(0, 16'h8200, 2, 16'hA0);
        prog(1, 16'hA000, 1, 16'hB0);
        hw(8'h04, 16'h0001);
        wait_clear(1, "R7 second slot");
        repeat (40) @(negedge clk);
        check("R7 resent count", rx_total - base_n, 5);
        hr(da(0, 0), v);
        check("R7 ready kept", v, 16'h8200);
        hw(da(0, 0), 16'h0000);

        // R7 continuous bit ignored in slave
        hw(8'h00, 16'h0000);
        rdy_mode = 2'd2;
        base_n = rx_total;
        prog(0, 16'hA200, 1, 16'hC0);
        hw(8'h04, 16'h0001);
        wait_clear(0, "R7 slave clears ready");
        repeat (10) @(negedge clk);
        check("R7 slave count", rx_total - base_n, 1);

        // R8 underrun in slave
        rdy_mode = 2'd1;
        hw(8'h02, 16'h0003);
        base_n = rx_total;
        prog(0, 16'hB000, 2, 16'hD0);
        hw(8'h04, 16'h0001);
        wait_clear(0, "R8 closed");
        hr(da(0, 0), v);
        check("R8 underrun word", v, 16'h3002);
        hr(8'h02, v);
        check("R8 error event", v, 2);
        check("R8 no bytes", rx_total - base_n, 0);

        // R9 multi-master error
        hw(8'h00, 16'h0001);
        hw(8'h02, 16'h0003);
        ss_in = 1'b1;
        base_n = rx_total;
        prog(0, 16'hB000, 3, 16'hD0);
        hw(8'h04, 16'h0001);
        wait_clear(0, "R9 closed");
        ss_in = 1'b0;
        hr(da(0, 0), v);
        check("R9 error word", v, 16'h3001);
        hr(8'h02, v);
        check("R9 error event", v, 2);
        check("R9 no bytes", rx_total - base_n, 0);

        // R13 hold during stall
        rdy_mode = 2'd0;
        prog(0, 16'hA000, 1, 16'hE0);
        hw(8'h04, 16'h0001);
        repeat (12) @(negedge clk);
        check("R13 valid held", {31'd0, tx_valid}, 1);
        check("R13 data held", {24'd0, tx_data}, {24'd0, bval(8'hE0)});
        rdy_mode = 2'd1;
        wait_clear(0, "R13 finished");

        // R5 irq masking, R11 write-one-to-clear
        hw(8'h02, 16'h0003);
        hw(8'h03, 16'h0001);
        prog(0, 16'hB000, 1, 16'h10);
        hw(8'h04, 16'h0001);
        wait_clear(0, "R5 done");
        @(negedge clk);
        check("R5 irq on", {31'd0, irq}, 1);
        hw(8'h02, 16'h0002);
        hr(8'h02, v);
        check("R11 other bit kept", v, 1);
        hw(8'h02, 16'h0001);
        hr(8'h02, v);
        check("R11 cleared", v, 0);
        check("R5 irq off", {31'd0, irq}, 0);
        hw(8'h03, 16'h0000);
        prog(0, 16'hB000, 1, 16'h10);
        hw(8'h04, 16'h0001);
        wait_clear(0, "R5 done masked");
        @(negedge clk);
        hr(8'h02, v);
        check("R5 event set", v, 1);
        check("R5 irq masked", {31'd0, irq}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule